// File: doc/BRIEF.md
# Boundary-Scan Test Access Port for a Synchronous Memory

This block is the test access port of a synchronous memory device. A test controller steps it with a test clock and a mode-select line. The 16-state controller walks the usual capture, shift and update phases for an instruction path and a data path. A 3-bit instruction picks which data register sits between the serial input and the serial output. The data registers are a 1-bit bypass stage, a 32-bit identification register and a 69-bit boundary register.

The boundary register captures a parallel snapshot of the memory's I/O ring. It has no update stage, so bits shifted into it never reach any pin. Two of the instructions raise an output-disable line. This line tells the pad logic to put the memory's data drivers into high impedance. A new instruction only takes effect when the controller leaves the update-instruction state.

The serial output changes on the falling test-clock edge. It comes with an enable that is high only while a shift state is active. The pad drives the output only when that enable is high.

Top module: `jtp_top`

## Requirements
- R1: The controller follows the standard 16-state sequence, sampling `tms` on the rising `tck` edge. `rst` high at a rising edge forces the test-reset state. Five consecutive rising edges with `tms` high also reach the test-reset state, from any state.
- R2: Entering the test-reset state (by `rst` or by `tms`) makes the current instruction 3'b001 (identification) and drops `out_hiz` to 0.
- R3: In the capture-instruction state the instruction shifter loads 3'b001. While shifting, bit 0 leaves first and `tdi` enters at bit 2. The shifted value becomes the current instruction when the controller leaves the update-instruction state.
- R4: Instruction 3'b001 selects the identification register. Capture-DR loads the ID_VALUE parameter into it, and it shifts out LSB first. `out_hiz` stays 0.
- R5: Instruction 3'b111 selects the 1-bit bypass stage. It captures 0, so one scan returns a 0 followed by `tdi` delayed by one shift. `out_hiz` stays 0.
- R6: The unused codes 3'b011, 3'b101 and 3'b110 act exactly as 3'b111 and leave `out_hiz` at 0.
- R7: Instruction 3'b100 (sample) selects the boundary register. Capture-DR copies `ring_snap[i]` into cell i, and cell 0 shifts out first. `out_hiz` stays 0. Shifted-in data is never transferred anywhere, and the next capture overwrites it.
- R8: Instruction 3'b000 captures and selects the boundary register like R7, and sets `out_hiz` to 1.
- R9: Instruction 3'b010 captures and selects the boundary register like R7, and sets `out_hiz` to 1.
- R10: `out_hiz` changes only at the rising edge that leaves the update-instruction state, or on entering the test-reset state. It stays high for as long as 3'b000 or 3'b010 is the current instruction.
- R11: `tdo` and `tdo_oe` change on the falling `tck` edge. `tdo_oe` is 1 exactly while the controller is in shift-DR or shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset, acts as test reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| ring_snap | input | 69 | Parallel I/O-ring snapshot for boundary capture |
| tdo | output | 1 | Serial data out, changes on falling tck |
| tdo_oe | output | 1 | Serial output enable, high in shift states |
| out_hiz | output | 1 | Forces the memory data outputs to high impedance |

## Verification
The bench keeps the default widths: a 3-bit instruction, a 32-bit identification register and a 69-bit boundary register. It overrides ID_VALUE with a distinctive pattern, so that a bit-order or capture error shows up in the identification scan. With the full 69-bit boundary length, the bench can shift a scan longer than the register and check that the shifted-in bits come back out at the end. It can also capture twice to show that shifted data never survives into the next capture. Every instruction code, including the three unused ones, is loaded. `out_hiz` is checked both on the update edge and after a reset by `tms` alone.

// File: rtl/jtp_pkg.sv
`timescale 1ns/1ps
package jtp_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_st_e;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPZ  = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;
  localparam logic [IR_W-1:0] IR_CAP_PAT = 3'b001;

  typedef enum logic [1:0] { SEL_BYP, SEL_ID, SEL_BSR } dr_sel_e;

  function automatic dr_sel_e dr_select(input logic [IR_W-1:0] op);
    case (op)
      OP_IDCODE:                      return SEL_ID;
      OP_EXTEST, OP_SAMPZ, OP_SAMPLE: return SEL_BSR;
      default:                        return SEL_BYP;
    endcase
  endfunction

  function automatic logic forces_hiz(input logic [IR_W-1:0] op);
    return (op == OP_EXTEST) || (op == OP_SAMPZ);
  endfunction

endpackage

// File: rtl/jtp_fsm.sv
`timescale 1ns/1ps
module jtp_fsm
  import jtp_pkg::*;
(
  input  logic    tck,
  input  logic    rst,
  input  logic    tms,
  output tap_st_e state_q,
  output tap_st_e state_n
);

  always_comb begin
    case (state_q)
      ST_RESET:  state_n = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   state_n = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: state_n = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_n = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_n = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_n = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_n = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: state_n = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: state_n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_n = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_n = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_n = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_n = tms ? ST_SEL_DR : ST_IDLE;
      default:   state_n = ST_RESET;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state_q <= ST_RESET;
    else     state_q <= state_n;
  end

endmodule

// File: rtl/jtp_shreg.sv
`timescale 1ns/1ps
module jtp_shreg #(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] cap_val,
  input  logic         sh,
  input  logic         tdi,
  output logic [W-1:0] q
);

  generate
    if (W == 1) begin : g_one
      always_ff @(posedge tck) begin
        if (rst)      q <= '0;
        else if (cap) q <= cap_val;
        else if (sh)  q <= tdi;
      end
    end else begin : g_multi
      always_ff @(posedge tck) begin
        if (rst)      q <= '0;
        else if (cap) q <= cap_val;
        else if (sh)  q <= {tdi, q[W-1:1]};
      end
    end
  endgenerate

endmodule

// File: rtl/jtp_ir.sv
`timescale 1ns/1ps
module jtp_ir
  import jtp_pkg::*;
(
  input  logic            tck,
  input  logic            rst,
  input  logic            tdi,
  input  tap_st_e         state_q,
  input  tap_st_e         state_n,
  output logic [IR_W-1:0] ir_sh,
  output logic [IR_W-1:0] ir_cur
);

  jtp_shreg #(.W(IR_W)) u_sh (
    .tck     (tck),
    .rst     (rst),
    .cap     (state_q == ST_CAP_IR),
    .cap_val (IR_CAP_PAT),
    .sh      (state_q == ST_SH_IR),
    .tdi     (tdi),
    .q       (ir_sh)
  );

  always_ff @(posedge tck) begin
    if (rst || state_n == ST_RESET) ir_cur <= OP_IDCODE;
    else if (state_q == ST_UPD_IR)  ir_cur <= ir_sh;
  end

endmodule

// File: rtl/jtp_dr.sv
`timescale 1ns/1ps
module jtp_dr
  import jtp_pkg::*;
#(
  parameter int          ID_W     = 32,
  parameter int          BSR_W    = 69,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1B30_5A4F
) (
  input  logic             tck,
  input  logic             rst,
  input  logic             tdi,
  input  tap_st_e          state_q,
  input  logic [IR_W-1:0]  ir_cur,
  input  logic [BSR_W-1:0] ring_snap,
  output logic             dr_lsb
);

  dr_sel_e          sel;
  logic             cap_any, sh_any;
  logic [0:0]       byp_q;
  logic [ID_W-1:0]  id_q;
  logic [BSR_W-1:0] bsr_q;

  assign sel     = dr_select(ir_cur);
  assign cap_any = (state_q == ST_CAP_DR);
  assign sh_any  = (state_q == ST_SH_DR);

  jtp_shreg #(.W(1)) u_byp (
    .tck(tck), .rst(rst),
    .cap(cap_any && sel == SEL_BYP), .cap_val(1'b0),
    .sh(sh_any && sel == SEL_BYP), .tdi(tdi), .q(byp_q)
  );

  jtp_shreg #(.W(ID_W)) u_id (
    .tck(tck), .rst(rst),
    .cap(cap_any && sel == SEL_ID), .cap_val(ID_VALUE),
    .sh(sh_any && sel == SEL_ID), .tdi(tdi), .q(id_q)
  );

  jtp_shreg #(.W(BSR_W)) u_bsr (
    .tck(tck), .rst(rst),
    .cap(cap_any && sel == SEL_BSR), .cap_val(ring_snap),
    .sh(sh_any && sel == SEL_BSR), .tdi(tdi), .q(bsr_q)
  );

  always_comb begin
    case (sel)
      SEL_ID:  dr_lsb = id_q[0];
      SEL_BSR: dr_lsb = bsr_q[0];
      default: dr_lsb = byp_q[0];
    endcase
  end

endmodule

// File: rtl/jtp_top.sv
`timescale 1ns/1ps
module jtp_top
  import jtp_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter int              BSR_W    = 69,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1B30_5A4F
) (
  input  logic             tck,
  input  logic             rst,
  input  logic             tms,
  input  logic             tdi,
  input  logic [BSR_W-1:0] ring_snap,
  output logic             tdo,
  output logic             tdo_oe,
  output logic             out_hiz
);

  tap_st_e         st_q, st_n;
  logic [IR_W-1:0] ir_sh, ir_cur;
  logic            dr_lsb;

  jtp_fsm u_fsm (
    .tck(tck), .rst(rst), .tms(tms), .state_q(st_q), .state_n(st_n)
  );

  jtp_ir u_ir (
    .tck(tck), .rst(rst), .tdi(tdi), .state_q(st_q), .state_n(st_n),
    .ir_sh(ir_sh), .ir_cur(ir_cur)
  );

  jtp_dr #(.ID_W(ID_W), .BSR_W(BSR_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .rst(rst), .tdi(tdi), .state_q(st_q), .ir_cur(ir_cur),
    .ring_snap(ring_snap), .dr_lsb(dr_lsb)
  );

  // Output-disable: loaded from the pending instruction when leaving Update-IR.
  always_ff @(posedge tck) begin
    if (rst || st_n == ST_RESET) out_hiz <= 1'b0;
    else if (st_q == ST_UPD_IR)  out_hiz <= forces_hiz(ir_sh);
  end

  // Serial output launched on the falling edge.
  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (st_q == ST_SH_DR) || (st_q == ST_SH_IR);
      tdo    <= (st_q == ST_SH_IR) ? ir_sh[0] : dr_lsb;
    end
  end

endmodule

// File: rtl/jtp_chk.sv
`timescale 1ns/1ps
module jtp_chk
  import jtp_pkg::*;
(
  input logic            tck,
  input logic            rst,
  input logic            tms,
  input tap_st_e         state_q,
  input logic [IR_W-1:0] ir_cur,
  input logic [IR_W-1:0] ir_sh,
  input logic            hiz,
  input logic            tdo_oe
);

  logic [2:0] ones_cnt;

  always_ff @(posedge tck) begin
    if (rst)                     ones_cnt <= '0;
    else if (!tms)               ones_cnt <= '0;
    else if (ones_cnt != 3'd5)   ones_cnt <= ones_cnt + 3'd1;
  end

  // R1
  tms_reset_chk: assert property (@(posedge tck) disable iff (rst)
    (ones_cnt == 3'd5) |-> (state_q == ST_RESET));

  // R2
  reset_state_chk: assert property (@(posedge tck) disable iff (rst)
    (state_q == ST_RESET) |-> (ir_cur == OP_IDCODE && !hiz));

  // R3
  ir_capture_chk: assert property (@(posedge tck) disable iff (rst)
    (state_q == ST_CAP_IR) |=> (ir_sh == IR_CAP_PAT));

  // R10
  hiz_rise_chk: assert property (@(posedge tck) disable iff (rst)
    $rose(hiz) |-> ($past(state_q) == ST_UPD_IR));

  // R10
  hiz_instr_chk: assert property (@(posedge tck) disable iff (rst)
    hiz |-> (ir_cur == OP_EXTEST || ir_cur == OP_SAMPZ));

  // R11
  tdo_enable_chk: assert property (@(posedge tck) disable iff (rst)
    tdo_oe == (state_q == ST_SH_DR || state_q == ST_SH_IR));

endmodule

bind jtp_top jtp_chk u_chk (
  .tck(tck), .rst(rst), .tms(tms), .state_q(st_q), .ir_cur(ir_cur),
  .ir_sh(ir_sh), .hiz(out_hiz), .tdo_oe(tdo_oe)
);

// File: tb/sim_jtp_top.sv
`timescale 1ns/1ps
module sim_jtp_top;

  localparam int BSR_W = 69;
  localparam logic [31:0] IDV = 32'h2C7A_91E5;

  logic tck = 1'b0, rst = 1'b1, tms = 1'b1, tdi = 1'b0;
  logic [BSR_W-1:0] ring = '0;
  logic tdo, tdo_oe, out_hiz;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic  exp_q[$];
  string tag_q[$];

  always #2.5 tck = ~tck;

  jtp_top #(.ID_VALUE(IDV)) u0 (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .ring_snap(ring),
    .tdo(tdo), .tdo_oe(tdo_oe), .out_hiz(out_hiz)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: each shifted bit is compared with the scoreboard head.
  always @(posedge tck) begin
    if (!rst && tdo_oe) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R11 actual=unexpected shift bit %b expected=none", tdo);
      end else begin
        automatic logic  e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, {127'b0, tdo}, {127'b0, e});
      end
    end
  end

  task automatic tick(input logic m, input logic d);
    @(negedge tck); #1;
    tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  // From idle: load an opcode, checking out_hiz before and after the update edge.
  task automatic shift_ir(input logic [2:0] op, input logic hz_old, input logic hz_new);
    exp_q.push_back(1'b1); tag_q.push_back("R3");
    exp_q.push_back(1'b0); tag_q.push_back("R3");
    exp_q.push_back(1'b0); tag_q.push_back("R3");
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 3; i++) tick(i == 2, op[i]);
    tick(1, 0);
    check("R10 hiz held in update-IR", {127'b0, out_hiz}, {127'b0, hz_old});
    tick(0, 0);
    check("R10 hiz after update-IR", {127'b0, out_hiz}, {127'b0, hz_new});
  endtask

  task automatic shift_dr(input int n, input logic [127:0] din,
                          input logic [127:0] dout, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(dout[i]); tag_q.push_back(tag);
    end
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) tick(i == n - 1, din[i]);
    tick(1, 0); tick(0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge tck);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [127:0] bp_in, bp_out, long_in, long_out;
    logic [BSR_W-1:0] snap_a, snap_b;
    snap_a = {5'h15, 64'hDEAD_BEEF_0123_4567};
    snap_b = {5'h0A, 64'h5A5A_0FF0_C3C3_9876};

    repeat (3) @(posedge tck);
    #1;
    check("R2 reset out_hiz", {127'b0, out_hiz}, 128'd0);
    check("R11 reset tdo_oe", {127'b0, tdo_oe}, 128'd0);
    @(negedge tck); #1; rst = 1'b0;
    tick(0, 0);

    // R4 default instruction after reset is identification
    shift_dr(32, 128'hFFFF_FFFF, {96'b0, IDV}, "R4");

    // R5 bypass
    bp_in = 128'hB2;
    bp_out = {bp_in[126:0], 1'b0};
    shift_ir(3'b111, 0, 0);
    shift_dr(8, bp_in, bp_out, "R5");

    // R6 unused codes behave as bypass
    shift_ir(3'b011, 0, 0);
    shift_dr(8, bp_in, bp_out, "R6 code 011");
    shift_ir(3'b101, 0, 0);
    shift_dr(8, 128'h4D, {127'h4D, 1'b0}, "R6 code 101");
    shift_ir(3'b110, 0, 0);
    shift_dr(8, bp_in, bp_out, "R6 code 110");

    // R7 sample: capture, no update, later capture replaces shifted data
    ring = snap_a;
    shift_ir(3'b100, 0, 0);
    shift_dr(BSR_W, {128{1'b1}}, {59'b0, snap_a}, "R7 capture");
    check("R7 out_hiz", {127'b0, out_hiz}, 128'd0);
    ring = snap_b;
    shift_dr(BSR_W, '0, {59'b0, snap_b}, "R7 recapture");

    // R8 extest: capture + output disable, and shift-through past the end
    ring = snap_a;
    shift_ir(3'b000, 0, 1);
    check("R8 out_hiz", {127'b0, out_hiz}, 128'd1);
    long_in  = 128'h9;
    long_out = {59'b0, snap_a} | (long_in << BSR_W);
    shift_dr(BSR_W + 4, long_in, long_out, "R8");
    check("R10 hiz persists", {127'b0, out_hiz}, 128'd1);

    // R1 / R2: five TMS-high edges from pause-IR release the disable
    tick(1, 0); tick(1, 0); tick(0, 0); tick(1, 0); tick(0, 0);
    for (int i = 0; i < 5; i++) tick(1, 0);
    check("R1 R2 tms reset clears hiz", {127'b0, out_hiz}, 128'd0);
    tick(0, 0);
    shift_dr(32, '0, {96'b0, IDV}, "R1 R2 id after tms reset");

    // R9 sample-with-disable, then synchronous reset
    ring = snap_b;
    shift_ir(3'b010, 0, 1);
    check("R9 out_hiz", {127'b0, out_hiz}, 128'd1);
    shift_dr(BSR_W, '0, {59'b0, snap_b}, "R9");
    @(negedge tck); #1; rst = 1'b1;
    @(posedge tck); #1;
    check("R2 sync reset clears hiz", {127'b0, out_hiz}, 128'd0);
    @(negedge tck); #1; rst = 1'b0;
    tick(0, 0);
    shift_dr(32, '0, {96'b0, IDV}, "R2 id after sync reset");

    // Extest loaded then replaced by sample releases the disable
    shift_ir(3'b000, 0, 1);
    shift_ir(3'b100, 1, 0);

    repeat (4) @(posedge tck);
    check("R11 all expected bits shifted", exp_q.size(), 128'd0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule